// File: doc/BRIEF.md
# Retired-Instruction Counter Timer

This block keeps a 64-bit event counter that advances by the number of instructions the core retires in each cycle, from zero up to the width of the retire port. It does not count clock cycles. A 32-bit compare value sits next to the counter. When a retire step carries the low 32 bits of the counter from below the compare value to at or above it, the block sets a sticky timer-pending flag. That flag feeds the core's interrupt logic.

Software reaches the block through a small register port. A 3-bit select chooses among the cycle, time and instret views of the counter, a writable full-width counter view, a high-half view and the compare register. A write takes effect on the next clock edge. A read returns data in the same cycle, together with an illegal-access flag. The crossing test uses a difference that is wider than the counter's low half, so the block catches a crossing even when several instructions retire in the same step and jump over the compare value.

Top module: `retire_timer`

## Requirements
- R1: After reset the counter, the compare register and the pending flag are all zero.
- R2: In every cycle with no counter write, the counter grows by `retireCnt` (0 to 7 with default parameters) and wraps modulo 2^64.
- R3: Reads with select 0, 1, 2 or 3 all return the same full 64-bit counter value.
- R4: Take L as the counter's low 32 bits and C as the compare value before an edge. If L < C and L + `retireCnt` >= C (unsigned, with no wrap of the sum), the pending flag is 1 after that edge. A step with L >= C, or with a zero retire count, never sets it.
- R5: Once set, the pending flag stays 1 until a compare write or reset. Retire steps and counter writes do not clear it.
- R6: A write with select 5 loads the compare register from `csrWdata[31:0]` and clears the pending flag. The clear wins over a crossing detected in the same cycle.
- R7: A write with select 3 loads all 64 counter bits. It wins over a retire increment in the same cycle, and that cycle can set no pending flag.
- R8: A write with select 4 replaces counter bits 63:32 with `csrWdata[31:0]` and keeps bits 31:0. The same-cycle retire count is discarded.
- R9: A read with select 4 returns counter bits 63:32, zero-extended, when `mode64` is 0. When `mode64` is 1 it raises `csrIllegal` and returns zero.
- R10: A read with select 6 or 7 raises `csrIllegal` and returns zero. Writes with select 0, 1, 2, 6 or 7 change neither the counter nor the compare register.
- R11: A read with select 5 returns the compare value, zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireCnt | input | RETIRE_W (3) | Instructions retired this cycle |
| mode64 | input | 1 | Core runs in 64-bit mode |
| csrRe | input | 1 | Register read request |
| csrWe | input | 1 | Register write request |
| csrSel | input | 3 | Register select (0..7) |
| csrWdata | input | COUNT_W (64) | Write data |
| csrRdata | output | COUNT_W (64) | Read data, same cycle |
| csrIllegal | output | 1 | Read of an undefined or mode-forbidden register |
| timerPending | output | 1 | Sticky timer-pending flag |

## Verification
Three sweeps test the crossing detector. Each one sets the counter's low half to every offset from two above to nine below a compare value, and retires every count from 0 to 7.
- With a compare value in mid-range, the sweep separates "reached exactly", "jumped over" and "fell one short".
- With a compare value of 1, the counter's low half starts wrapped just below 2^32. This shows that a low half numerically above the compare value never fires, even when the sum wraps past zero.
- With a compare value of 0xFFFFFFFF, the sum carries past 32 bits. This separates a detector that compares full-width sums from one that truncates the sum.

Directed sequences then cover the write-versus-retire collisions, the stickiness of the pending flag and the mode-dependent legality of high-half reads.

// File: rtl/rit_pkg.sv
package rit_pkg;

  typedef enum logic [2:0] {
    SEL_CYC   = 3'd0,
    SEL_WALL  = 3'd1,
    SEL_RET   = 3'd2,
    SEL_CNT   = 3'd3,
    SEL_CNTHI = 3'd4,
    SEL_CMP   = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } csrSel_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FULL = 2'd1,
    RD_HIGH = 2'd2,
    RD_CMP  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   wrFull;
    logic   wrHigh;
    logic   wrCmp;
    rdSrc_e rdSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/rit_ctrl.sv
module rit_ctrl
  import rit_pkg::*;
(
  input  logic       csrRe,
  input  logic       csrWe,
  input  logic [2:0] csrSel,
  input  logic       mode64,
  output ctlStrobe_t strb,
  output logic       csrIllegal
);

  csrSel_e selE;

  always_comb begin
    selE        = csrSel_e'(csrSel);
    strb.wrFull = 1'b0;
    strb.wrHigh = 1'b0;
    strb.wrCmp  = 1'b0;
    strb.rdSrc  = RD_NONE;
    csrIllegal  = 1'b0;

    // write decode: alias views and reserved codes are read-only / ignored
    if (csrWe) begin
      case (selE)
        SEL_CNT:   strb.wrFull = 1'b1;
        SEL_CNTHI: strb.wrHigh = 1'b1;
        SEL_CMP:   strb.wrCmp  = 1'b1;
        default:   ;
      endcase
    end

    // read decode
    if (csrRe) begin
      case (selE)
        SEL_CYC, SEL_WALL, SEL_RET, SEL_CNT: strb.rdSrc = RD_FULL;
        SEL_CNTHI: begin
          if (mode64) csrIllegal = 1'b1;
          else        strb.rdSrc = RD_HIGH;
        end
        SEL_CMP:   strb.rdSrc = RD_CMP;
        default:   csrIllegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rit_cross.sv
module rit_cross #(
  parameter int LOW_W    = 32,
  parameter int RETIRE_W = 3
) (
  input  logic [LOW_W-1:0]    lowCnt,
  input  logic [LOW_W-1:0]    cmpVal,
  input  logic [RETIRE_W-1:0] retireCnt,
  output logic                crossing
);

  localparam int BASE_W = (LOW_W > RETIRE_W) ? LOW_W : RETIRE_W;
  localparam int DIFF_W = BASE_W + 2;

  logic [DIFF_W-1:0] diffBefore;
  logic [DIFF_W-1:0] diffAfter;

  // sign flips from negative to non-negative when the step reaches compare
  always_comb begin
    diffBefore = DIFF_W'(lowCnt) - DIFF_W'(cmpVal);
    diffAfter  = diffBefore + DIFF_W'(retireCnt);
    crossing   = diffBefore[DIFF_W-1] & ~diffAfter[DIFF_W-1];
  end

endmodule

// File: rtl/rit_datapath.sv
module rit_datapath
  import rit_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int LOW_W    = 32,
  parameter int RETIRE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [RETIRE_W-1:0] retireCnt,
  input  logic [COUNT_W-1:0]  wdata,
  output logic [COUNT_W-1:0]  countQ,
  output logic [LOW_W-1:0]    cmpQ,
  output logic                pendingQ,
  output logic [COUNT_W-1:0]  rdata
);

  localparam int HI_W = COUNT_W - LOW_W;

  logic [COUNT_W-1:0] countD;
  logic [LOW_W-1:0]   cmpD;
  logic               pendingD;
  logic               crossing;
  logic               cntWrite;

  rit_cross #(
    .LOW_W   (LOW_W),
    .RETIRE_W(RETIRE_W)
  ) uCross (
    .lowCnt   (countQ[LOW_W-1:0]),
    .cmpVal   (cmpQ),
    .retireCnt(retireCnt),
    .crossing (crossing)
  );

  assign cntWrite = strb.wrFull | strb.wrHigh;

  always_comb begin
    if (strb.wrFull)
      countD = wdata;
    else if (strb.wrHigh)
      countD = {wdata[HI_W-1:0], countQ[LOW_W-1:0]};
    else
      countD = countQ + COUNT_W'(retireCnt);

    cmpD = strb.wrCmp ? wdata[LOW_W-1:0] : cmpQ;

    if (strb.wrCmp)
      pendingD = 1'b0;
    else if (crossing && !cntWrite)
      pendingD = 1'b1;
    else
      pendingD = pendingQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      cmpQ     <= '0;
      pendingQ <= 1'b0;
    end else begin
      countQ   <= countD;
      cmpQ     <= cmpD;
      pendingQ <= pendingD;
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_FULL: rdata = countQ;
      RD_HIGH: rdata = COUNT_W'(countQ[COUNT_W-1:LOW_W]);
      RD_CMP:  rdata = COUNT_W'(cmpQ);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/retire_timer.sv
module retire_timer
  import rit_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int LOW_W    = 32,
  parameter int RETIRE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RETIRE_W-1:0] retireCnt,
  input  logic                mode64,
  input  logic                csrRe,
  input  logic                csrWe,
  input  logic [2:0]          csrSel,
  input  logic [COUNT_W-1:0]  csrWdata,
  output logic [COUNT_W-1:0]  csrRdata,
  output logic                csrIllegal,
  output logic                timerPending
);

  ctlStrobe_t         strb;
  logic [COUNT_W-1:0] countVal;
  logic [LOW_W-1:0]   cmpVal;

  rit_ctrl uCtrl (
    .csrRe     (csrRe),
    .csrWe     (csrWe),
    .csrSel    (csrSel),
    .mode64    (mode64),
    .strb      (strb),
    .csrIllegal(csrIllegal)
  );

  rit_datapath #(
    .COUNT_W (COUNT_W),
    .LOW_W   (LOW_W),
    .RETIRE_W(RETIRE_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .retireCnt(retireCnt),
    .wdata    (csrWdata),
    .countQ   (countVal),
    .cmpQ     (cmpVal),
    .pendingQ (timerPending),
    .rdata    (csrRdata)
  );

endmodule

// File: rtl/retire_timer_chk.sv
module retire_timer_chk
  import rit_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int LOW_W    = 32,
  parameter int RETIRE_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [RETIRE_W-1:0] retireCnt,
  input logic                mode64,
  input logic                csrRe,
  input logic                csrWe,
  input logic [2:0]          csrSel,
  input logic [COUNT_W-1:0]  csrWdata,
  input logic [COUNT_W-1:0]  csrRdata,
  input logic                csrIllegal,
  input logic                timerPending,
  input logic [COUNT_W-1:0]  countVal,
  input logic [LOW_W-1:0]    cmpVal
);

  a_r2_count_advance: assert property (@(posedge clk) disable iff (!rstN)
    !csrWe |=> countVal == $past(countVal) + COUNT_W'($past(retireCnt)));

  a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timerPending && !(csrWe && csrSel == SEL_CMP)) |=> timerPending);

  a_r6_cmp_clears: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrSel == SEL_CMP) |=> (!timerPending && cmpVal == $past(csrWdata[LOW_W-1:0])));

  a_r8_high_write: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrSel == SEL_CNTHI) |=>
      (countVal[LOW_W-1:0] == $past(countVal[LOW_W-1:0]) &&
       countVal[COUNT_W-1:LOW_W] == $past(csrWdata[COUNT_W-LOW_W-1:0])));

  a_r9_high_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrSel == SEL_CNTHI && mode64) |-> (csrIllegal && csrRdata == '0));

  a_r4_needs_retire: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerPending) |-> $past(retireCnt) != '0);

endmodule

bind retire_timer retire_timer_chk #(
  .COUNT_W (COUNT_W),
  .LOW_W   (LOW_W),
  .RETIRE_W(RETIRE_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .retireCnt   (retireCnt),
  .mode64      (mode64),
  .csrRe       (csrRe),
  .csrWe       (csrWe),
  .csrSel      (csrSel),
  .csrWdata    (csrWdata),
  .csrRdata    (csrRdata),
  .csrIllegal  (csrIllegal),
  .timerPending(timerPending),
  .countVal    (countVal),
  .cmpVal      (cmpVal)
);

// File: tb/sim_retire_timer.sv
module sim_retire_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  retireCnt = '0;
  logic        mode64 = 1'b0;
  logic        csrRe = 1'b0;
  logic        csrWe = 1'b0;
  logic [2:0]  csrSel = '0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic        csrIllegal;
  logic        timerPending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  retire_timer u0 (
    .clk(clk), .rstN(rstN), .retireCnt(retireCnt), .mode64(mode64),
    .csrRe(csrRe), .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .csrIllegal(csrIllegal), .timerPending(timerPending)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs held across the rising edge, released after it
  task automatic step(input logic [2:0] r, input logic we, input logic [2:0] sel,
                      input logic [63:0] wd);
    retireCnt = r; csrWe = we; csrSel = sel; csrWdata = wd;
    @(posedge clk); #1;
    retireCnt = '0; csrWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdCsr(input logic [2:0] sel, input logic m64,
                       output logic [63:0] d, output logic ill);
    mode64 = m64; csrSel = sel; csrRe = 1'b1;
    #1;
    d = csrRdata; ill = csrIllegal;
    csrRe = 1'b0; mode64 = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic        ill;
    logic [63:0] expCnt;
    logic [31:0] cmpList [3];
    cmpList[0] = 32'd100; cmpList[1] = 32'd1; cmpList[2] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdCsr(3'd3, 1'b0, d, ill); chk("R1 count", d, 64'd0);
    rdCsr(3'd5, 1'b0, d, ill); chk("R1 compare", d, 64'd0);
    chk("R1 pending", {63'd0, timerPending}, 64'd0);

    // R2 accumulate several retire counts
    step(3'd3, 0, 3'd0, 0); step(3'd7, 0, 3'd0, 0);
    step(3'd0, 0, 3'd0, 0); step(3'd5, 0, 3'd0, 0);
    rdCsr(3'd3, 1'b0, d, ill); chk("R2 accumulate", d, 64'd15);
    step(3'd0, 1, 3'd3, 64'hFFFF_FFFF_FFFF_FFFE);
    step(3'd5, 0, 3'd0, 0);
    rdCsr(3'd3, 1'b0, d, ill); chk("R2 wrap", d, 64'd3);

    // R3 alias views
    step(3'd0, 1, 3'd3, 64'h0123_4567_89AB_CDEF);
    for (int s = 0; s < 4; s++) begin
      rdCsr(3'(s), 1'b0, d, ill);
      chk("R3 alias read", d, 64'h0123_4567_89AB_CDEF);
    end

    // R4 crossing sweep
    for (int c = 0; c < 3; c++) begin
      for (int off = -2; off <= 9; off++) begin
        for (int r = 0; r < 8; r++) begin
          logic [31:0] low;
          logic        expP;
          low = cmpList[c] - 32'(off);
          step(3'd0, 1, 3'd5, {32'd0, cmpList[c]});
          step(3'd0, 1, 3'd3, {32'd0, low});
          step(3'(r), 0, 3'd0, 0);
          expP = (low < cmpList[c]) &&
                 (({32'd0, low} + 64'(r)) >= {32'd0, cmpList[c]});
          chk("R4 crossing", {63'd0, timerPending}, {63'd0, expP});
          rdCsr(3'd3, 1'b0, d, ill);
          chk("R2 sweep count", d, {32'd0, low} + 64'(r));
        end
      end
    end

    // R5 stickiness
    step(3'd0, 1, 3'd5, 64'd20);
    step(3'd0, 1, 3'd3, 64'd18);
    step(3'd3, 0, 3'd0, 0);
    chk("R5 set", {63'd0, timerPending}, 64'd1);
    for (int i = 0; i < 5; i++) step(3'd7, 0, 3'd0, 0);
    chk("R5 after retires", {63'd0, timerPending}, 64'd1);
    step(3'd0, 1, 3'd3, 64'd0);
    chk("R5 after count write", {63'd0, timerPending}, 64'd1);
    step(3'd0, 1, 3'd5, 64'd20);
    chk("R5 cleared by compare", {63'd0, timerPending}, 64'd0);

    // R6 compare write beats same-cycle crossing; R11 readback
    step(3'd0, 1, 3'd5, 64'd50);
    step(3'd0, 1, 3'd3, 64'd48);
    step(3'd4, 1, 3'd5, 64'hFFFF_FFFF_0000_00C8);
    chk("R6 clear wins", {63'd0, timerPending}, 64'd0);
    rdCsr(3'd5, 1'b0, d, ill); chk("R11 compare read", d, 64'd200);
    rdCsr(3'd3, 1'b0, d, ill); chk("R6 count still advances", d, 64'd52);

    // R7 full write beats retire, no crossing
    step(3'd0, 1, 3'd5, 64'd10);
    step(3'd0, 1, 3'd3, 64'd5);
    step(3'd7, 1, 3'd3, 64'd8);
    rdCsr(3'd3, 1'b0, d, ill); chk("R7 write wins", d, 64'd8);
    chk("R7 no pending", {63'd0, timerPending}, 64'd0);

    // R8 high-half write
    step(3'd0, 1, 3'd3, 64'h1111_2222_3333_4444);
    step(3'd5, 1, 3'd4, 64'h5555_6666_AAAA_BBBB);
    rdCsr(3'd3, 1'b0, d, ill); chk("R8 high write", d, 64'hAAAA_BBBB_3333_4444);

    // R9 high read by mode
    rdCsr(3'd4, 1'b0, d, ill);
    chk("R9 high read 32", d, 64'h0000_0000_AAAA_BBBB);
    chk("R9 legal 32", {63'd0, ill}, 64'd0);
    rdCsr(3'd4, 1'b1, d, ill);
    chk("R9 high read 64 data", d, 64'd0);
    chk("R9 illegal 64", {63'd0, ill}, 64'd1);

    // R10 reserved codes and ignored writes
    rdCsr(3'd6, 1'b0, d, ill);
    chk("R10 code6 illegal", {63'd0, ill}, 64'd1); chk("R10 code6 data", d, 64'd0);
    rdCsr(3'd7, 1'b0, d, ill);
    chk("R10 code7 illegal", {63'd0, ill}, 64'd1);
    step(3'd0, 1, 3'd0, 64'hDEAD);
    step(3'd0, 1, 3'd7, 64'hBEEF);
    step(3'd0, 1, 3'd6, 64'hF00D);
    rdCsr(3'd3, 1'b0, d, ill); chk("R10 count unchanged", d, 64'hAAAA_BBBB_3333_4444);
    rdCsr(3'd5, 1'b0, d, ill); chk("R10 compare unchanged", d, 64'd10);

    // R1 reset again clears everything
    step(3'd0, 1, 3'd5, 64'd30);
    step(3'd0, 1, 3'd3, 64'd29);
    step(3'd2, 0, 3'd0, 0);
    rstN = 1'b0;
    step(3'd0, 0, 3'd0, 0);
    rstN = 1'b1;
    chk("R1 pending after reset", {63'd0, timerPending}, 64'd0);
    rdCsr(3'd3, 1'b0, d, ill); chk("R1 count after reset", d, 64'd0);
    expCnt = 64'd0;
    rdCsr(3'd5, 1'b0, d, ill); chk("R1 compare after reset", d, expCnt);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule